// File: doc/BRIEF.md
# Sequential multiply/divide unit

This block is an iterative arithmetic unit built around a small state machine. A single shift engine handles a 16x16 multiply, a 16/16 divide and a 32/16 divide, each in unsigned or signed form. Signed operations take operand magnitudes first, run the unsigned iteration, and then restore the signs of the results. The engine retires one bit per clock: shift-and-add for products and restoring subtraction for quotients.

The user presents operands and a mode, then pulses `start` for one clock. The operands are captured on that edge. `ready` falls on the next cycle and rises again when the result, the zero flag and the sign flag are valid. These outputs then stay unchanged until the next start. A divide by a zero divisor skips the iteration and completes at once, with `div_err` set.

State machine: `ST_IDLE` waits for start after reset. `ST_PREP` computes magnitudes and checks for a zero divisor. `ST_STEP` runs one iteration per cycle. `ST_POST` restores signs and sets the flags. `ST_DONE` holds the result.

The transitions are:
- IDLE→PREP and DONE→PREP on start.
- PREP→DONE on a zero divisor in a divide mode.
- PREP→STEP otherwise.
- STEP→STEP while the step counter is non-zero.
- STEP→POST when it reaches zero.
- POST→DONE.

Top module: `seq_muldiv`

## Requirements
- R1: With `op_mode` = 00 the result is the unsigned 32-bit product of `opa_lo` and `opb`; `dvd_hi` has no effect.
- R2: With `op_mode` = 01 the result is the two's-complement 32-bit product of `opa_lo` and `opb` read as signed values.
- R3: With `op_mode` = 10 and `wide_div` = 0, `opa_lo` is divided by `opb` unsigned; the quotient lands in result bits 31:16 and the remainder in bits 15:0; `dvd_hi` has no effect.
- R4: With `op_mode` = 11 the division is signed: the quotient is truncated toward zero and is negative when the operand signs differ, and the remainder carries the sign of the dividend.
- R5: With `wide_div` = 1 in a divide mode, the dividend is {`dvd_hi`,`opa_lo`} (32 bits, signed in mode 11) and the divisor is `opb`; results are defined when the quotient fits in 16 bits.
- R6: A start seen while the unit is idle or done drives `ready` low on the next cycle. `ready` returns high when the operation completes. `result` holds steady for as long as `ready` stays high.
- R7: `ready` is low for as long as `rst` is high, and stays low after reset until an operation completes.
- R8: A divide with `opb` = 0 raises `div_err` together with `ready` two cycles after the start edge; `div_err` is only ever high in a divide mode with a zero divisor and clears on the next start.
- R9: With a valid result, `zero_flag` is 1 exactly when the full product is zero (multiply) or the quotient is zero (divide).
- R10: With a valid result in a signed mode, `neg_flag` equals the top bit of the product (multiply) or of the quotient (divide).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that captures the operands and launches an operation |
| op_mode | input | 2 | 00 unsigned multiply, 01 signed multiply, 10 unsigned divide, 11 signed divide |
| wide_div | input | 1 | 1 selects the 32-bit dividend in divide modes |
| dvd_hi | input | 16 | Upper dividend word (wide divide only) |
| opa_lo | input | 16 | First factor, or the dividend (lower word when wide) |
| opb | input | 16 | Second factor or divisor |
| result | output | 32 | Product, or {quotient, remainder} |
| ready | output | 1 | Result valid |
| div_err | output | 1 | Divisor was zero |
| zero_flag | output | 1 | Product or quotient is zero |
| neg_flag | output | 1 | Sign bit of the product or quotient |

## Verification
The embedded properties check the following on every cycle:
- `ready` is held low by reset.
- A start always drops `ready`.
- `div_err` never appears without `ready`, a divide mode and a zero divisor.
- The result stays frozen while `ready` is high.
- The flags agree with the result word.
- The partial remainder of a divide stays below the divisor.
- The step counter stays within bound.

Only the bench's scenarios can show that the numbers are correct. These scenarios cover the signed and unsigned products, the signs of quotient and remainder, the 32-bit dividend path, the extreme operands, and the early finish of a divide by zero.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_STEP,
        ST_POST,
        ST_DONE
    } md_state_e;

    typedef enum logic [1:0] {
        OP_UMUL = 2'b00,
        OP_SMUL = 2'b01,
        OP_UDIV = 2'b10,
        OP_SDIV = 2'b11
    } md_op_e;

    function automatic logic op_is_div(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic op_is_signed(input logic [1:0] m);
        return m[0];
    endfunction

endpackage

// File: rtl/muldiv_fsm.sv
module muldiv_fsm
    import muldiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic is_div,
    input  logic wide,
    input  logic divisor_zero,
    output logic accept,
    output logic load,
    output logic step,
    output logic post,
    output logic ready,
    output logic err
);
    localparam int CW = $clog2(2 * W) + 1;
    localparam logic [CW-1:0] LAST_WIDE   = CW'(2 * W - 1);
    localparam logic [CW-1:0] LAST_NARROW = CW'(W - 1);

    md_state_e       state_q, state_n;
    logic [CW-1:0]   cnt_q;
    logic            div0_hit;

    always_comb begin
        state_n  = state_q;
        accept   = 1'b0;
        load     = 1'b0;
        step     = 1'b0;
        post     = 1'b0;
        div0_hit = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_n = ST_PREP;
                    accept  = 1'b1;
                end
            end
            ST_PREP: begin
                if (is_div && divisor_zero) begin
                    state_n  = ST_DONE;
                    div0_hit = 1'b1;
                end else begin
                    state_n = ST_STEP;
                    load    = 1'b1;
                end
            end
            ST_STEP: begin
                step = 1'b1;
                if (cnt_q == '0) begin
                    state_n = ST_POST;
                end
            end
            ST_POST: begin
                post    = 1'b1;
                state_n = ST_DONE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (is_div && wide) ? LAST_WIDE : LAST_NARROW;
        end else if (step && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b0;
            err   <= 1'b0;
        end else begin
            ready <= (state_n == ST_DONE);
            if (accept) begin
                err <= 1'b0;
            end else if (div0_hit) begin
                err <= 1'b1;
            end
        end
    end

    // R7: reset forces ready low on the following edge
    p_ready_low_in_reset_r7: assert property (@(posedge clk) rst |=> !ready);

    // R6: an accepted start always removes ready
    p_start_drops_ready_r6: assert property (
        @(posedge clk) disable iff (rst) accept |=> !ready);

    // R8: an error is only reported with a completed operation
    p_err_with_ready_r8: assert property (
        @(posedge clk) disable iff (rst) err |-> ready);

    p_cnt_in_range: assert property (
        @(posedge clk) disable iff (rst) cnt_q <= LAST_WIDE);

endmodule

// File: rtl/muldiv_sign.sv
module muldiv_sign #(
    parameter int W = 16
) (
    input  logic [1:0]     mode,
    input  logic           wide,
    input  logic [W-1:0]   hi,
    input  logic [W-1:0]   lo,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] mag_a,
    output logic [W-1:0]   mag_b,
    output logic           neg_main,
    output logic           neg_rem
);
    localparam int DW = 2 * W;

    logic           sgn, wdiv, a_neg, b_neg;
    logic [DW-1:0]  raw_a;

    always_comb begin
        sgn   = mode[0];
        wdiv  = mode[1] && wide;
        raw_a = wdiv ? {hi, lo} : {{W{1'b0}}, lo};
        a_neg = sgn && (wdiv ? hi[W-1] : lo[W-1]);
        b_neg = sgn && b[W-1];
        if (!a_neg) begin
            mag_a = raw_a;
        end else if (wdiv) begin
            mag_a = ~raw_a + 1'b1;
        end else begin
            mag_a = {{W{1'b0}}, ~lo + 1'b1};
        end
        mag_b    = b_neg ? (~b + 1'b1) : b;
        neg_main = a_neg ^ b_neg;
        neg_rem  = a_neg;
    end

endmodule

// File: rtl/muldiv_engine.sv
module muldiv_engine #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic           is_div,
    input  logic           wide,
    input  logic [2*W-1:0] mag_a,
    input  logic [W-1:0]   mag_b,
    output logic [2*W-1:0] prod,
    output logic [W-1:0]   quo,
    output logic [W-1:0]   rem
);
    localparam int DW = 2 * W;

    logic [W-1:0]  hi_q, hi_n;
    logic [DW-1:0] lo_q, lo_n;
    logic [W-1:0]  dv_q;

    logic [W:0]    msum;
    logic [W:0]    shifted;
    logic [W-1:0]  diff;
    logic          fits;

    always_comb begin
        msum    = {1'b0, hi_q} + (lo_q[0] ? {1'b0, dv_q} : '0);
        shifted = {hi_q, lo_q[DW-1]};
        fits    = shifted >= {1'b0, dv_q};
        diff    = shifted[W-1:0] - dv_q;
        if (is_div) begin
            hi_n = fits ? diff : shifted[W-1:0];
            lo_n = {lo_q[DW-2:0], fits};
        end else begin
            hi_n = msum[W:1];
            lo_n = {{W{1'b0}}, msum[0], lo_q[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
            dv_q <= '0;
        end else if (load) begin
            hi_q <= '0;
            dv_q <= mag_b;
            lo_q <= (is_div && !wide) ? {mag_a[W-1:0], {W{1'b0}}} : mag_a;
        end else if (step) begin
            hi_q <= hi_n;
            lo_q <= lo_n;
        end
    end

    assign prod = {hi_q, lo_q[W-1:0]};
    assign quo  = lo_q[W-1:0];
    assign rem  = hi_q;

    // R3: restoring division keeps the partial remainder below the divisor
    p_rem_below_divisor_r3: assert property (
        @(posedge clk) disable iff (rst)
        ($past(step) && is_div) |-> (hi_q < dv_q));

endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv
    import muldiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       op_mode,
    input  logic             wide_div,
    input  logic [W-1:0]     dvd_hi,
    input  logic [W-1:0]     opa_lo,
    input  logic [W-1:0]     opb,
    output logic [2*W-1:0]   result,
    output logic             ready,
    output logic             div_err,
    output logic             zero_flag,
    output logic             neg_flag
);
    localparam int DW = 2 * W;

    logic [1:0]    mode_q;
    logic          wide_q;
    logic [W-1:0]  hi_q, lo_q, b_q;

    logic          accept, load, step, post;
    logic [DW-1:0] mag_a;
    logic [W-1:0]  mag_b;
    logic          neg_main, neg_rem;
    logic [DW-1:0] prod;
    logic [W-1:0]  quo, rem;

    logic [DW-1:0] prod_f;
    logic [W-1:0]  quo_f, rem_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= OP_UMUL;
            wide_q <= 1'b0;
            hi_q   <= '0;
            lo_q   <= '0;
            b_q    <= '0;
        end else if (accept) begin
            mode_q <= op_mode;
            wide_q <= wide_div;
            hi_q   <= dvd_hi;
            lo_q   <= opa_lo;
            b_q    <= opb;
        end
    end

    muldiv_fsm #(.W(W)) fsm_i (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .is_div       (op_is_div(mode_q)),
        .wide         (wide_q),
        .divisor_zero (b_q == '0),
        .accept       (accept),
        .load         (load),
        .step         (step),
        .post         (post),
        .ready        (ready),
        .err          (div_err)
    );

    muldiv_sign #(.W(W)) sign_i (
        .mode     (mode_q),
        .wide     (wide_q),
        .hi       (hi_q),
        .lo       (lo_q),
        .b        (b_q),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .neg_main (neg_main),
        .neg_rem  (neg_rem)
    );

    muldiv_engine #(.W(W)) engine_i (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (step),
        .is_div (op_is_div(mode_q)),
        .wide   (wide_q),
        .mag_a  (mag_a),
        .mag_b  (mag_b),
        .prod   (prod),
        .quo    (quo),
        .rem    (rem)
    );

    always_comb begin
        prod_f = neg_main ? (~prod + 1'b1) : prod;
        quo_f  = neg_main ? (~quo + 1'b1) : quo;
        rem_f  = neg_rem  ? (~rem + 1'b1) : rem;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            zero_flag <= 1'b0;
            neg_flag  <= 1'b0;
        end else if (accept) begin
            result    <= '0;
            zero_flag <= 1'b0;
            neg_flag  <= 1'b0;
        end else if (post) begin
            if (op_is_div(mode_q)) begin
                result    <= {quo_f, rem_f};
                zero_flag <= (quo_f == '0);
                neg_flag  <= quo_f[W-1];
            end else begin
                result    <= prod_f;
                zero_flag <= (prod_f == '0);
                neg_flag  <= prod_f[DW-1];
            end
        end
    end

    // R8: error only for a divide whose captured divisor is zero
    p_err_cause_r8: assert property (
        @(posedge clk) disable iff (rst)
        div_err |-> (op_is_div(mode_q) && b_q == '0));

    // R6: a completed result does not move while ready stays high
    p_result_held_r6: assert property (
        @(posedge clk) disable iff (rst)
        (ready && $past(ready)) |-> $stable(result));

    // R9: zero flag agrees with the product or the quotient field
    p_zero_flag_r9: assert property (
        @(posedge clk) disable iff (rst)
        (ready && !div_err) |->
        (zero_flag == (op_is_div(mode_q) ? (result[DW-1:W] == '0) : (result == '0))));

    // R10: sign flag agrees with the top bit of product or quotient
    p_sign_flag_r10: assert property (
        @(posedge clk) disable iff (rst)
        (ready && !div_err && op_is_signed(mode_q)) |-> (neg_flag == result[DW-1]));

endmodule

// File: tb/seq_muldiv_tb_top.sv
module seq_muldiv_tb_top;

    localparam int NV = 18;
    // fields: [50:49] mode, [48] wide, [47:32] high word, [31:16] low word, [15:0] opb
    localparam logic [50:0] VECS [NV] = '{
        {2'b00, 1'b0, 16'hFFFF, 16'h1234, 16'h5678},
        {2'b00, 1'b0, 16'h0000, 16'hFFFF, 16'hFFFF},
        {2'b00, 1'b0, 16'h5A5A, 16'h0000, 16'h1234},
        {2'b01, 1'b0, 16'h0000, 16'hFFFE, 16'h0003},
        {2'b01, 1'b0, 16'h0000, 16'h8000, 16'h8000},
        {2'b01, 1'b0, 16'h0000, 16'h7FFF, 16'h8001},
        {2'b01, 1'b0, 16'h0000, 16'h0000, 16'hFFFF},
        {2'b10, 1'b0, 16'h0000, 16'd1000, 16'd7},
        {2'b10, 1'b0, 16'h0000, 16'd5,    16'd9},
        {2'b10, 1'b0, 16'hABCD, 16'hFFFF, 16'h0001},
        {2'b11, 1'b0, 16'h0000, 16'hFFF9, 16'h0002},
        {2'b11, 1'b0, 16'h0000, 16'h0007, 16'hFFFE},
        {2'b11, 1'b0, 16'h0000, 16'hFFF9, 16'hFFFE},
        {2'b10, 1'b1, 16'h0001, 16'h0000, 16'h0002},
        {2'b10, 1'b1, 16'h1234, 16'h5678, 16'hFFFF},
        {2'b11, 1'b1, 16'hFFFF, 16'h0000, 16'h0004},
        {2'b11, 1'b1, 16'h0000, 16'h1000, 16'hFFF0},
        {2'b11, 1'b1, 16'hFFFE, 16'h7961, 16'h0007}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op_mode = 2'b00;
    logic        wide_div = 1'b0;
    logic [15:0] dvd_hi = '0;
    logic [15:0] opa_lo = '0;
    logic [15:0] opb = '0;
    logic [31:0] result;
    logic        ready, div_err, zero_flag, neg_flag;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    seq_muldiv dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op_mode   (op_mode),
        .wide_div  (wide_div),
        .dvd_hi    (dvd_hi),
        .opa_lo    (opa_lo),
        .opb       (opb),
        .result    (result),
        .ready     (ready),
        .div_err   (div_err),
        .zero_flag (zero_flag),
        .neg_flag  (neg_flag)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [1:0] m, input logic w,
                                          input logic [15:0] h, input logic [15:0] l,
                                          input logic [15:0] d);
        longint a, bb, q, r;
        case (m)
            2'b00: begin
                a = longint'(l); bb = longint'(d);
                return 32'(a * bb);
            end
            2'b01: begin
                a = longint'($signed(l)); bb = longint'($signed(d));
                return 32'(a * bb);
            end
            2'b10: begin
                a  = w ? longint'({h, l}) : longint'(l);
                bb = longint'(d);
                q = a / bb; r = a % bb;
                return {16'(q), 16'(r)};
            end
            default: begin
                a  = w ? longint'($signed({h, l})) : longint'($signed(l));
                bb = longint'($signed(d));
                q = a / bb; r = a % bb;
                return {16'(q), 16'(r)};
            end
        endcase
    endfunction

    task automatic launch(input logic [1:0] m, input logic w, input logic [15:0] h,
                          input logic [15:0] l, input logic [15:0] d);
        @(negedge clk);
        op_mode = m; wide_div = w; dvd_hi = h; opa_lo = l; opb = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(ready == 1'b0, "R6 ready low after start", {31'b0, ready}, 32'h0);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 80) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [31:0] exp_v, held;
        string tag;

        // R7: ready held low during reset and afterwards until a completion
        repeat (4) begin
            @(negedge clk);
            check(ready == 1'b0, "R7 ready during reset", {31'b0, ready}, 32'h0);
        end
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(ready == 1'b0, "R7 ready idle after reset", {31'b0, ready}, 32'h0);
        check(div_err == 1'b0, "R7 err after reset", {31'b0, div_err}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] m;
            logic w;
            logic [15:0] h, l, d;
            m = VECS[i][50:49]; w = VECS[i][48];
            h = VECS[i][47:32]; l = VECS[i][31:16]; d = VECS[i][15:0];
            exp_v = model(m, w, h, l, d);
            if (m == 2'b00) tag = "R1";
            else if (m == 2'b01) tag = "R2";
            else if (w) tag = "R5";
            else if (m == 2'b10) tag = "R3";
            else tag = "R4";
            launch(m, w, h, l, d);
            wait_ready(n);
            check(ready == 1'b1, "R6 completion", {31'b0, ready}, 32'h1);
            check(result == exp_v, tag, result, exp_v);
            check(div_err == 1'b0, "R8 no error", {31'b0, div_err}, 32'h0);
            if (m[1]) begin
                check(zero_flag == (exp_v[31:16] == 16'h0), "R9 quotient zero",
                      {31'b0, zero_flag}, {31'b0, exp_v[31:16] == 16'h0});
            end else begin
                check(zero_flag == (exp_v == 32'h0), "R9 product zero",
                      {31'b0, zero_flag}, {31'b0, exp_v == 32'h0});
            end
            if (m[0]) begin
                check(neg_flag == exp_v[31], "R10 sign flag",
                      {31'b0, neg_flag}, {31'b0, exp_v[31]});
            end
        end

        // R6: result held while ready, even as the operand inputs move
        held = result;
        @(negedge clk);
        opa_lo = 16'h1111; opb = 16'h2222; dvd_hi = 16'h3333; op_mode = 2'b00;
        repeat (5) @(negedge clk);
        check(result == held && ready, "R6 result held", result, held);

        // R8: unsigned divide by zero finishes at once
        launch(2'b10, 1'b0, 16'h0, 16'h1234, 16'h0000);
        @(negedge clk);
        check(ready == 1'b1, "R8 early ready", {31'b0, ready}, 32'h1);
        check(div_err == 1'b1, "R8 error raised", {31'b0, div_err}, 32'h1);

        // R8: signed wide divide by zero
        launch(2'b11, 1'b1, 16'h8000, 16'h0001, 16'h0000);
        @(negedge clk);
        check(ready && div_err, "R8 signed wide error", {30'b0, ready, div_err}, 32'h3);

        // R8: a following multiply by zero must not report an error
        launch(2'b00, 1'b0, 16'h0, 16'h1234, 16'h0000);
        check(div_err == 1'b0, "R8 error cleared on start", {31'b0, div_err}, 32'h0);
        wait_ready(n);
        check(div_err == 1'b0 && result == 32'h0, "R8 mul by zero no error",
              result, 32'h0);
        check(zero_flag == 1'b1, "R9 zero product", {31'b0, zero_flag}, 32'h1);

        // R7: reset in the middle of an operation
        launch(2'b11, 1'b1, 16'h0001, 16'h0000, 16'h0003);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(ready == 1'b0, "R7 ready during mid-op reset", {31'b0, ready}, 32'h0);
        end
        rst = 1'b0;
        repeat (40) @(negedge clk);
        check(ready == 1'b0, "R7 no completion after reset", {31'b0, ready}, 32'h0);

        // R2: most negative times minus one
        launch(2'b01, 1'b0, 16'h0, 16'h8000, 16'hFFFF);
        wait_ready(n);
        check(result == 32'h00008000, "R2 min times minus one", result, 32'h00008000);
        check(neg_flag == 1'b0, "R10 positive product", {31'b0, neg_flag}, 32'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule